// File: doc/BRIEF.md
# Ethernet MAC control register file

This block holds the software-visible configuration and status words of an Ethernet MAC behind a simple 32-bit word-addressed read/write port. It keeps the mode word, the interrupt cause and enable words, the three inter-packet-gap words, the frame length limits, the collision settings, the transmit descriptor count, the PHY management words, the 48-bit station address, the two multicast hash words, and a window onto a small descriptor memory. The transmit and receive engines sit beside it. They receive the current mode word, the station address and single-cycle strobes. The strobes mark enable edges, a reload of the receive ring index, and a soft reset. The engines send back interrupt events.

Event pulses from the engines set bits in the cause word. Software clears a cause bit by writing 1 to it. A level interrupt line follows the enabled causes. A PHY management read command runs a two-state machine. The machine has the states `MG_IDLE` and `MG_READ`. A write to the command word with the read bit set takes the `start` transition from `MG_IDLE` to `MG_READ`. `MG_READ` always takes the `finish` transition back to `MG_IDLE` on the next edge. On that edge it loads the response word. A soft reset forces `MG_IDLE`. There is no serial engine: the response is a fixed value chosen from the PHY register number.

Top module: `macreg_top`

## Requirements
- R1: After reset the registers read as follows: mode (word 0x00) 0x0000A000, back-to-back gap (0x03) 0x12, gap part 1 (0x04) 0x0C, gap part 2 (0x05) 0x12, length limits (0x06) 0x003C0600, collision settings (0x07) 0x000F003F, management mode (0x0A) 0x64, transmit descriptor count (0x08) 0x40. Every other register reads 0, the interrupt line is low and all strobes are low.
- R2: Writing the cause word (0x01) clears each cause bit written as 1 and leaves bits written as 0. A pulse on `irq_event_i` sets the matching cause bits. The line falls after a cause write if (cause AND enable) becomes zero.
- R3: Writing the enable word (0x02) drives the line to the OR of (cause AND new enable) on the next cycle. An event on an enabled bit raises the line one cycle after the pulse.
- R4: The descriptor count (0x08) keeps only bits 7:0. A write to it pulses `rx_idx_load_o` one cycle later, with `rx_idx_value_o` equal to twice the stored value.
- R5: Station word low (0x10) holds station bytes 3,2,1,0 from bit 31 down. Station word high (0x11) keeps byte 5 in bits 15:8 and byte 4 in bits 7:0 and reads 0 above bit 15. `mac_addr_o` carries byte n in bits 8n+7:8n.
- R6: Writes to the management receive-data word (0x0E) and the management status word (0x0F) have no effect.
- R7: A mode write with bit 11 set restores every register to its reset value, clears the descriptor memory and returns the management machine to `MG_IDLE`. One cycle later it pulses `soft_rst_o` and `rx_idx_load_o` (value 0x80).
- R8: Writing the command word (0x0B, 3 bits kept) with bit 1 set starts a read. Status bit 1 reads 1 in the cycle after the write. One cycle later the receive-data word holds the result. The PHY address is bits 4:0 of the management address word (0x0C) and the register number is bits 12:8. When the PHY address equals `PHY_ADDR`, the result for registers 0..4 is 0x1100, 0x782D, 0x0141, 0x0C20, 0x01E1, and 0 for any other register. When the address does not match, the result is 0xFFFF.
- R9: Mode bit 1 enables transmit and bit 0 enables receive. One cycle after a mode change, the block pulses `tx_en_rise_o`/`tx_en_fall_o` on a 0-to-1 or 1-to-0 change of bit 1, and `rx_en_rise_o`/`rx_en_fall_o` on a change of bit 0. A receive-enable rise also pulses `rx_idx_load_o` with twice the count.
- R10: Word addresses `DESC_BASE` to `DESC_BASE+DESC_WORDS-1` map one-to-one onto descriptor words. Any address not listed reads 0.
- R11: A read request returns its data on `rd_data_o` after the next clock edge and holds it until the next read.
- R12: The remaining registers (0x03-0x07, 0x09, 0x0A, 0x0C, 0x0D, 0x12, 0x13) store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, registered |
| irq_event_i | input | IRQ_W | Cause-set pulses from the engines |
| irq_o | output | 1 | Level interrupt |
| mode_o | output | 32 | Current mode word |
| mac_addr_o | output | 48 | Station address, byte 0 in bits 7:0 |
| tx_en_rise_o | output | 1 | Transmit enable turned on |
| tx_en_fall_o | output | 1 | Transmit enable turned off |
| rx_en_rise_o | output | 1 | Receive enable turned on |
| rx_en_fall_o | output | 1 | Receive enable turned off |
| rx_idx_load_o | output | 1 | Reload the receive ring index |
| rx_idx_value_o | output | 9 | Index to load |
| soft_rst_o | output | 1 | Soft reset was requested |

## Verification
Every result in this block is due one edge after the stimulus. Read data, strobes, index reloads, line changes and the management busy flag all appear after the edge that takes the request or event. The management result appears after a second edge. The bench drives each request at a falling edge and holds it through one rising edge. It then samples at the following falling edge, where the single-cycle strobes and the new read data are both stable. For a management read, the status word is read in the very next request and the receive-data word in the one after, so that both the busy cycle and the result are seen.

// File: rtl/macreg_pkg.sv
package macreg_pkg;
    localparam int unsigned CNT_W = 8;

    // Word offsets of the register map
    localparam int unsigned A_MODE  = 'h00;
    localparam int unsigned A_CAUSE = 'h01;
    localparam int unsigned A_ENAB  = 'h02;
    localparam int unsigned A_GAPB  = 'h03;
    localparam int unsigned A_GAP1  = 'h04;
    localparam int unsigned A_GAP2  = 'h05;
    localparam int unsigned A_LIMS  = 'h06;
    localparam int unsigned A_COLL  = 'h07;
    localparam int unsigned A_DCNT  = 'h08;
    localparam int unsigned A_CTRL  = 'h09;
    localparam int unsigned A_MGMOD = 'h0A;
    localparam int unsigned A_MGCMD = 'h0B;
    localparam int unsigned A_MGADR = 'h0C;
    localparam int unsigned A_MGTXD = 'h0D;
    localparam int unsigned A_MGRXD = 'h0E;
    localparam int unsigned A_MGSTA = 'h0F;
    localparam int unsigned A_STLO  = 'h10;
    localparam int unsigned A_STHI  = 'h11;
    localparam int unsigned A_HSH0  = 'h12;
    localparam int unsigned A_HSH1  = 'h13;

    // Mode word bit positions
    localparam int unsigned MB_RXEN = 0;
    localparam int unsigned MB_TXEN = 1;
    localparam int unsigned MB_RST  = 11;
    localparam int unsigned CMD_RD  = 1;

    // Reset values
    localparam logic [31:0] RV_MODE  = 32'h0000_A000;
    localparam logic [31:0] RV_GAPB  = 32'h0000_0012;
    localparam logic [31:0] RV_GAP1  = 32'h0000_000C;
    localparam logic [31:0] RV_GAP2  = 32'h0000_0012;
    localparam logic [31:0] RV_LIMS  = 32'h003C_0600;
    localparam logic [31:0] RV_COLL  = 32'h000F_003F;
    localparam logic [31:0] RV_MGMOD = 32'h0000_0064;
    localparam logic [CNT_W-1:0] RV_DCNT = 8'h40;

    typedef enum logic [0:0] {MG_IDLE, MG_READ} mgmt_state_e;

    function automatic logic [15:0] phy_reg_value(input logic [4:0] r);
        logic [15:0] v;
        case (r)
            5'd0:    v = 16'h1100;
            5'd1:    v = 16'h782D;
            5'd2:    v = 16'h0141;
            5'd3:    v = 16'h0C20;
            5'd4:    v = 16'h01E1;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/macreg_irq.sv
module macreg_irq #(
    parameter int W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         src_we_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] event_i,
    output logic [W-1:0] src_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] src_q, src_d, mask_q, mask_d;
    logic         line_q, line_d;

    always_comb begin
        src_d  = (src_q & ~(src_we_i ? wdata_i : '0)) | event_i;
        mask_d = mask_we_i ? wdata_i : mask_q;
        line_d = line_q;
        if (mask_we_i)                   line_d = |(src_d & mask_d);
        else if (|(event_i & mask_q))    line_d = 1'b1;
        else if (src_we_i)               line_d = line_q & |(src_d & mask_q);
        if (clr_i) begin
            src_d  = '0;
            mask_d = '0;
            line_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            src_q  <= '0;
            mask_q <= '0;
            line_q <= 1'b0;
        end else begin
            src_q  <= src_d;
            mask_q <= mask_d;
            line_q <= line_d;
        end
    end

    assign src_o  = src_q;
    assign mask_o = mask_q;
    assign irq_o  = line_q;

    // R3: the line is only high while an enabled cause is pending
    a_r3_line_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> |(src_q & mask_q));
    // R2: written ones are gone on the next cycle
    a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_we_i && !clr_i && event_i == '0) |=> ((src_q & $past(wdata_i)) == '0));
    // R3: enable write re-evaluates the line
    a_r3_mask_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_we_i && !clr_i) |=> (irq_o == |(src_q & mask_q)));
endmodule

// File: rtl/macreg_mgmt.sv
module macreg_mgmt
    import macreg_pkg::*;
#(
    parameter int PHY_ADDR = 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        clr_i,
    input  logic        read_req_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  reg_i,
    output logic        busy_o,
    output logic [15:0] rx_data_o
);
    mgmt_state_e state_q, state_d;
    logic [4:0]  phy_q, reg_q;
    logic [15:0] rx_q;
    logic        load;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= MG_IDLE;
        else         state_q <= state_d;
    end

    // transitions: start (IDLE->READ), finish (READ->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MG_IDLE: if (read_req_i) state_d = MG_READ;
            MG_READ: state_d = MG_IDLE;
        endcase
        if (clr_i) state_d = MG_IDLE;
    end

    // outputs
    always_comb begin
        busy_o = (state_q == MG_READ);
        load   = (state_q == MG_READ) && !clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phy_q <= '0;
            reg_q <= '0;
            rx_q  <= '0;
        end else if (clr_i) begin
            phy_q <= '0;
            reg_q <= '0;
            rx_q  <= '0;
        end else begin
            if (read_req_i && state_q == MG_IDLE) begin
                phy_q <= phy_i;
                reg_q <= reg_i;
            end
            if (load)
                rx_q <= (phy_q == 5'(PHY_ADDR)) ? phy_reg_value(reg_q) : 16'hFFFF;
        end
    end

    assign rx_data_o = rx_q;

    // R8: a read occupies exactly one busy cycle
    a_r8_one_busy_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == MG_READ) |=> (state_q == MG_IDLE));
    // R8: a foreign PHY address answers all ones
    a_r8_foreign_phy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == MG_READ && !clr_i && phy_q != 5'(PHY_ADDR)) |=> (rx_data_o == 16'hFFFF));
endmodule

// File: rtl/macreg_desc_ram.sv
module macreg_desc_ram #(
    parameter int DEPTH = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clr_i,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] idx_i,
    input  logic [31:0]              wdata_i,
    output logic [31:0]              rdata_o
);
    localparam int IDX_W = $clog2(DEPTH);
    logic [DEPTH-1:0][31:0] words;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                              word_q <= '0;
            else if (clr_i)                           word_q <= '0;
            else if (we_i && idx_i == IDX_W'(w))      word_q <= wdata_i;
        end
        assign words[w] = word_q;
    end

    assign rdata_o = words[idx_i];
endmodule

// File: rtl/macreg_top.sv
module macreg_top
    import macreg_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DESC_WORDS = 32,
    parameter int DESC_BASE  = 'h100,
    parameter int IRQ_W      = 7,
    parameter int PHY_ADDR   = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    output logic [31:0]       rd_data_o,
    input  logic [IRQ_W-1:0]  irq_event_i,
    output logic              irq_o,
    output logic [31:0]       mode_o,
    output logic [47:0]       mac_addr_o,
    output logic              tx_en_rise_o,
    output logic              tx_en_fall_o,
    output logic              rx_en_rise_o,
    output logic              rx_en_fall_o,
    output logic              rx_idx_load_o,
    output logic [CNT_W:0]    rx_idx_value_o,
    output logic              soft_rst_o
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    logic wr, rd, soft_hit;
    logic [31:0] mode_q, mode_d;
    logic [31:0] gapb_q, gap1_q, gap2_q, lims_q, coll_q, ctrl_q, mgmod_q;
    logic [31:0] mgadr_q, mgtxd_q, stlo_q, hsh0_q, hsh1_q;
    logic [15:0] sthi_q;
    logic [2:0]  mgcmd_q;
    logic [CNT_W-1:0] dcnt_q, dcnt_d;
    logic [IRQ_W-1:0] src, mask;
    logic        mg_busy;
    logic [15:0] mg_rx;
    logic [ADDR_W-1:0] desc_off;
    logic        in_desc;
    logic [31:0] desc_rdata, rd_d;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    assign wr       = req_valid_i && req_write_i;
    assign rd       = req_valid_i && !req_write_i;
    assign soft_hit = wr && hit(req_addr_i, A_MODE) && req_wdata_i[MB_RST];
    assign desc_off = req_addr_i - ADDR_W'(DESC_BASE);
    assign in_desc  = (req_addr_i >= ADDR_W'(DESC_BASE)) && (desc_off < ADDR_W'(DESC_WORDS));

    always_comb begin
        mode_d = mode_q;
        dcnt_d = dcnt_q;
        if (wr && hit(req_addr_i, A_MODE)) mode_d = req_wdata_i;
        if (wr && hit(req_addr_i, A_DCNT)) dcnt_d = req_wdata_i[CNT_W-1:0];
        if (soft_hit) begin
            mode_d = RV_MODE;
            dcnt_d = RV_DCNT;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= RV_MODE;  dcnt_q <= RV_DCNT;
            gapb_q <= RV_GAPB;  gap1_q <= RV_GAP1;  gap2_q <= RV_GAP2;
            lims_q <= RV_LIMS;  coll_q <= RV_COLL;  mgmod_q <= RV_MGMOD;
            ctrl_q <= '0; mgadr_q <= '0; mgtxd_q <= '0; mgcmd_q <= '0;
            stlo_q <= '0; sthi_q <= '0; hsh0_q <= '0; hsh1_q <= '0;
        end else begin
            mode_q <= mode_d;
            dcnt_q <= dcnt_d;
            if (soft_hit) begin
                gapb_q <= RV_GAPB;  gap1_q <= RV_GAP1;  gap2_q <= RV_GAP2;
                lims_q <= RV_LIMS;  coll_q <= RV_COLL;  mgmod_q <= RV_MGMOD;
                ctrl_q <= '0; mgadr_q <= '0; mgtxd_q <= '0; mgcmd_q <= '0;
                stlo_q <= '0; sthi_q <= '0; hsh0_q <= '0; hsh1_q <= '0;
            end else if (wr) begin
                if (hit(req_addr_i, A_GAPB))  gapb_q  <= req_wdata_i;
                if (hit(req_addr_i, A_GAP1))  gap1_q  <= req_wdata_i;
                if (hit(req_addr_i, A_GAP2))  gap2_q  <= req_wdata_i;
                if (hit(req_addr_i, A_LIMS))  lims_q  <= req_wdata_i;
                if (hit(req_addr_i, A_COLL))  coll_q  <= req_wdata_i;
                if (hit(req_addr_i, A_CTRL))  ctrl_q  <= req_wdata_i;
                if (hit(req_addr_i, A_MGMOD)) mgmod_q <= req_wdata_i;
                if (hit(req_addr_i, A_MGCMD)) mgcmd_q <= req_wdata_i[2:0];
                if (hit(req_addr_i, A_MGADR)) mgadr_q <= req_wdata_i;
                if (hit(req_addr_i, A_MGTXD)) mgtxd_q <= req_wdata_i;
                if (hit(req_addr_i, A_STLO))  stlo_q  <= req_wdata_i;
                if (hit(req_addr_i, A_STHI))  sthi_q  <= req_wdata_i[15:0];
                if (hit(req_addr_i, A_HSH0))  hsh0_q  <= req_wdata_i;
                if (hit(req_addr_i, A_HSH1))  hsh1_q  <= req_wdata_i;
            end
        end
    end

    // Side-effect strobes toward the engines
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_en_rise_o <= 1'b0; tx_en_fall_o <= 1'b0;
            rx_en_rise_o <= 1'b0; rx_en_fall_o <= 1'b0;
            rx_idx_load_o <= 1'b0; rx_idx_value_o <= '0; soft_rst_o <= 1'b0;
        end else begin
            tx_en_rise_o  <= !mode_q[MB_TXEN] &&  mode_d[MB_TXEN];
            tx_en_fall_o  <=  mode_q[MB_TXEN] && !mode_d[MB_TXEN];
            rx_en_rise_o  <= !mode_q[MB_RXEN] &&  mode_d[MB_RXEN];
            rx_en_fall_o  <=  mode_q[MB_RXEN] && !mode_d[MB_RXEN];
            soft_rst_o    <= soft_hit;
            rx_idx_load_o <= soft_hit || (wr && hit(req_addr_i, A_DCNT))
                             || (!mode_q[MB_RXEN] && mode_d[MB_RXEN]);
            rx_idx_value_o <= {dcnt_d, 1'b0};
        end
    end

    macreg_irq #(.W(IRQ_W)) irq_i (
        .clk_i, .rst_ni, .clr_i(soft_hit),
        .src_we_i (wr && hit(req_addr_i, A_CAUSE)),
        .mask_we_i(wr && hit(req_addr_i, A_ENAB)),
        .wdata_i  (req_wdata_i[IRQ_W-1:0]),
        .event_i  (irq_event_i),
        .src_o(src), .mask_o(mask), .irq_o(irq_o)
    );

    macreg_mgmt #(.PHY_ADDR(PHY_ADDR)) mgmt_i (
        .clk_i, .rst_ni, .clr_i(soft_hit),
        .read_req_i(wr && hit(req_addr_i, A_MGCMD) && req_wdata_i[CMD_RD]),
        .phy_i(mgadr_q[4:0]), .reg_i(mgadr_q[12:8]),
        .busy_o(mg_busy), .rx_data_o(mg_rx)
    );

    macreg_desc_ram #(.DEPTH(DESC_WORDS)) desc_i (
        .clk_i, .rst_ni, .clr_i(soft_hit),
        .we_i(wr && in_desc), .idx_i(desc_off[IDX_W-1:0]),
        .wdata_i(req_wdata_i), .rdata_o(desc_rdata)
    );

    always_comb begin
        rd_d = '0;
        if (in_desc) rd_d = desc_rdata;
        else if (hit(req_addr_i, A_MODE))  rd_d = mode_q;
        else if (hit(req_addr_i, A_CAUSE)) rd_d = 32'(src);
        else if (hit(req_addr_i, A_ENAB))  rd_d = 32'(mask);
        else if (hit(req_addr_i, A_GAPB))  rd_d = gapb_q;
        else if (hit(req_addr_i, A_GAP1))  rd_d = gap1_q;
        else if (hit(req_addr_i, A_GAP2))  rd_d = gap2_q;
        else if (hit(req_addr_i, A_LIMS))  rd_d = lims_q;
        else if (hit(req_addr_i, A_COLL))  rd_d = coll_q;
        else if (hit(req_addr_i, A_DCNT))  rd_d = 32'(dcnt_q);
        else if (hit(req_addr_i, A_CTRL))  rd_d = ctrl_q;
        else if (hit(req_addr_i, A_MGMOD)) rd_d = mgmod_q;
        else if (hit(req_addr_i, A_MGCMD)) rd_d = 32'(mgcmd_q);
        else if (hit(req_addr_i, A_MGADR)) rd_d = mgadr_q;
        else if (hit(req_addr_i, A_MGTXD)) rd_d = mgtxd_q;
        else if (hit(req_addr_i, A_MGRXD)) rd_d = 32'(mg_rx);
        else if (hit(req_addr_i, A_MGSTA)) rd_d = {30'd0, mg_busy, 1'b0};
        else if (hit(req_addr_i, A_STLO))  rd_d = stlo_q;
        else if (hit(req_addr_i, A_STHI))  rd_d = 32'(sthi_q);
        else if (hit(req_addr_i, A_HSH0))  rd_d = hsh0_q;
        else if (hit(req_addr_i, A_HSH1))  rd_d = hsh1_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  rd_data_o <= '0;
        else if (rd)  rd_data_o <= rd_d;
    end

    assign mode_o     = mode_q;
    assign mac_addr_o = {sthi_q, stlo_q};

    // R4: a count write reloads the receive index with twice the low byte
    a_r4_idx_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && hit(req_addr_i, A_DCNT) && !soft_hit)
        |=> (rx_idx_load_o && rx_idx_value_o == {$past(req_wdata_i[CNT_W-1:0]), 1'b0}));
    // R9: rise and fall never pulse together
    a_r9_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({tx_en_rise_o, tx_en_fall_o}) && $onehot0({rx_en_rise_o, rx_en_fall_o}));
    // R7: soft reset lands the mode word on its reset value
    a_r7_soft_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_hit |=> (mode_o == RV_MODE && soft_rst_o));
    // R6: the management receive word ignores bus writes
    a_r6_rxd_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && hit(req_addr_i, A_MGRXD) && !mg_busy) |=> $stable(mg_rx));
endmodule

// File: tb/macreg_top_tb_top.sv
module macreg_top_tb_top;
    localparam int ADDR_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [6:0]  irq_event = '0;
    logic irq, tx_rise, tx_fall, rx_rise, rx_fall, idx_load, soft_rst;
    logic [31:0] mode;
    logic [47:0] mac_addr;
    logic [8:0]  idx_value;

    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    macreg_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_data_o(rd_data),
        .irq_event_i(irq_event), .irq_o(irq), .mode_o(mode), .mac_addr_o(mac_addr),
        .tx_en_rise_o(tx_rise), .tx_en_fall_o(tx_fall), .rx_en_rise_o(rx_rise),
        .rx_en_fall_o(rx_fall), .rx_idx_load_o(idx_load), .rx_idx_value_o(idx_value),
        .soft_rst_o(soft_rst)
    );

    // addr, write data, expected read-back (R12 plus ignored writes, R6)
    localparam logic [72:0] VEC [0:11] = '{
        {9'h003, 32'h0000_0015, 32'h0000_0015},
        {9'h004, 32'h0000_0007, 32'h0000_0007},
        {9'h005, 32'h8000_0030, 32'h8000_0030},
        {9'h006, 32'h0040_0800, 32'h0040_0800},
        {9'h007, 32'h000A_0020, 32'h000A_0020},
        {9'h009, 32'hFFFF_0007, 32'hFFFF_0007},
        {9'h00A, 32'h0000_01FF, 32'h0000_01FF},
        {9'h00D, 32'h0000_BEEF, 32'h0000_BEEF},
        {9'h012, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
        {9'h013, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
        {9'h00E, 32'h0000_1234, 32'h0000_0000},
        {9'h00F, 32'h0000_FFFF, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_event(input logic [6:0] v);
        irq_event = v;
        @(negedge clk);
        irq_event = '0;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(9'h000, r); check("R1 mode", r, 32'h0000_A000);
        bus_read(9'h003, r); check("R1 gap b2b", r, 32'h12);
        bus_read(9'h004, r); check("R1 gap1", r, 32'h0C);
        bus_read(9'h005, r); check("R1 gap2", r, 32'h12);
        bus_read(9'h006, r); check("R1 limits", r, 32'h003C_0600);
        bus_read(9'h007, r); check("R1 collision", r, 32'h000F_003F);
        bus_read(9'h00A, r); check("R1 mgmt mode", r, 32'h64);
        bus_read(9'h008, r); check("R1 count", r, 32'h40);
        bus_read(9'h001, r); check("R1 cause", r, 32'h0);
        bus_read(9'h012, r); check("R1 hash0", r, 32'h0);
        check("R1 irq low", irq, 0);
        check("R1 strobes low", {tx_rise, tx_fall, rx_rise, rx_fall, idx_load, soft_rst}, 0);

        // Vector table walk: R12 and R6
        for (int i = 0; i < 12; i++) begin
            bus_write(VEC[i][72:64], VEC[i][63:32]);
            bus_read(VEC[i][72:64], r);
            check((VEC[i][72:64] >= 9'h00E) ? "R6 read-only word" : "R12 store",
                  r, VEC[i][31:0]);
        end

        // R11: read data held until next read
        @(negedge clk);
        check("R11 read data held", rd_data, 32'h0);
        bus_read(9'h012, r); check("R11 read latency", r, 32'hA5A5_5A5A);

        // R5: station packing
        bus_write(9'h010, 32'h4433_2211);
        bus_write(9'h011, 32'hABCD_6655);
        bus_read(9'h011, r); check("R5 high word 16 bits", r, 32'h6655);
        check("R5 station bytes", mac_addr, 48'h6655_4433_2211);

        // R4: count keeps low byte, reloads receive index
        bus_write(9'h008, 32'h0000_01A5);
        check("R4 index load", {idx_load, idx_value}, {1'b1, 9'h14A});
        bus_read(9'h008, r); check("R4 count low byte", r, 32'hA5);
        check("R4 load is one cycle", idx_load, 0);

        // R9: enable edges
        bus_write(9'h000, 32'h0000_A003);
        check("R9 both rises", {tx_rise, tx_fall, rx_rise, rx_fall}, 4'b1010);
        check("R9 rx rise reloads index", {idx_load, idx_value}, {1'b1, 9'h14A});
        bus_write(9'h000, 32'h0000_A001);
        check("R9 tx fall only", {tx_rise, tx_fall, rx_rise, rx_fall}, 4'b0100);
        check("R9 no reload on tx fall", idx_load, 0);
        @(negedge clk);
        check("R9 strobes single cycle", {tx_rise, tx_fall, rx_rise, rx_fall}, 4'b0000);
        check("R9 mode out", mode, 32'h0000_A001);

        // R2 / R3: interrupt causes and line
        bus_write(9'h002, 32'h05);
        check("R3 mask with no cause", irq, 0);
        pulse_event(7'h02);
        check("R3 unmasked event no line", irq, 0);
        pulse_event(7'h04);
        check("R3 masked event raises line", irq, 1);
        bus_read(9'h001, r); check("R2 causes set", r, 32'h06);
        bus_write(9'h001, 32'h04);
        check("R2 line drops", irq, 0);
        bus_read(9'h001, r); check("R2 only written ones cleared", r, 32'h02);
        bus_write(9'h002, 32'h02);
        check("R3 mask write raises line", irq, 1);
        bus_write(9'h002, 32'h00);
        check("R3 mask write drops line", irq, 0);
        bus_write(9'h002, 32'h03);
        pulse_event(7'h01);
        bus_write(9'h001, 32'h01);
        check("R2 line stays while cause left", irq, 1);
        bus_write(9'h001, 32'h02);
        check("R2 last cause cleared", irq, 0);

        // R8: management read
        bus_write(9'h00C, 32'h0000_0101);
        bus_write(9'h00B, 32'h0000_0002);
        bus_read(9'h00F, r); check("R8 busy flag", r, 32'h2);
        bus_read(9'h00E, r); check("R8 matching phy reg1", r, 32'h782D);
        bus_read(9'h00F, r); check("R8 idle again", r, 32'h0);
        bus_write(9'h00C, 32'h0000_0401);
        bus_write(9'h00B, 32'h0000_0002);
        @(negedge clk);
        bus_read(9'h00E, r); check("R8 matching phy reg4", r, 32'h01E1);
        bus_write(9'h00C, 32'h0000_0503);
        bus_write(9'h00B, 32'h0000_0002);
        @(negedge clk);
        bus_read(9'h00E, r); check("R8 foreign phy", r, 32'hFFFF);
        bus_write(9'h00C, 32'h0000_0901);
        bus_write(9'h00B, 32'h0000_0002);
        @(negedge clk);
        bus_read(9'h00E, r); check("R8 unknown reg", r, 32'h0);
        bus_write(9'h00E, 32'h0000_5555);
        bus_read(9'h00E, r); check("R6 rx data write ignored", r, 32'h0);

        // R10: descriptor window and unmapped space
        bus_write(9'h100, 32'hDEAD_BEEF);
        bus_write(9'h11F, 32'h1234_5678);
        bus_read(9'h100, r); check("R10 first word", r, 32'hDEAD_BEEF);
        bus_read(9'h11F, r); check("R10 last word", r, 32'h1234_5678);
        bus_read(9'h101, r); check("R10 neighbour untouched", r, 32'h0);
        bus_write(9'h120, 32'hFFFF_FFFF);
        bus_read(9'h120, r); check("R10 beyond window", r, 32'h0);
        bus_read(9'h050, r); check("R10 unmapped", r, 32'h0);

        // R7: soft reset
        bus_write(9'h000, 32'h0000_0801);
        check("R7 strobes", {soft_rst, idx_load, idx_value, rx_fall}, {1'b1, 1'b1, 9'h080, 1'b1});
        check("R7 mode", mode, 32'h0000_A000);
        bus_read(9'h004, r); check("R7 gap1 restored", r, 32'h0C);
        bus_read(9'h008, r); check("R7 count restored", r, 32'h40);
        bus_read(9'h100, r); check("R7 descriptor cleared", r, 32'h0);
        bus_read(9'h002, r); check("R7 mask cleared", r, 32'h0);
        bus_read(9'h00E, r); check("R7 mgmt rx cleared", r, 32'h0);
        check("R7 station cleared", mac_addr, 48'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule